// File: doc/BRIEF.md
# Relocatable indirect-window GPIO bank

This block gives software 22 general-purpose pins in three groups: 8 pins numbered 10–17, 6 pins numbered 20–25 and 8 pins numbered 30–37. Pin values are never mapped straight into I/O space. Software first writes a group number to an index port, then reads or writes that group's byte through a companion data port. The index/data pair sits at one of four fixed I/O address pairs. A control byte in a separate configuration space picks the pair and turns the window on or off.

Each pin also has its own configuration byte in that configuration space. The byte sets three things: whether the pin is an input or an output, whether its level is inverted, and whether it follows an alternate-function signal instead of its data latch. The block drives a tristate enable for every pin, drives output levels and samples input levels through a two-flop synchronizer. To change one pin, software reads its group byte, changes one bit and writes the byte back.

Top module: `gpio_window_bank`

## Requirements
- R1: After reset, the window is disabled and uses pair 0. Every configuration byte reads 0x01, so all pins are inputs and `pin_oe` is all zero. All data latches are 0.
- R2: The window is enabled only while bit 7 of the control byte (configuration address `CTRL_ADDR`) is 1. While it is 0, I/O writes change neither the index nor any latch, and I/O reads return 0x00.
- R3: Bits 1:0 of the control byte choose the index/data I/O addresses: 0 gives 0xE0/0xE1, 1 gives 0xE2/0xE3, 2 gives 0xE4/0xE5 and 3 gives 0xEA/0xEB. The other pairs do not respond.
- R4: A write to the index port loads the index register. A read of the index port returns that register. The index keeps its value when the window is disabled or moved.
- R5: Index 1 selects pins 10–17 (bit n is pin 1n). Index 2 selects pins 20–25 in bits 5:0; bits 7:6 read 0 and are not stored. Index 3 selects pins 30–37.
- R6: When the index is any other value, a data-port read returns 0x00 and a data-port write changes no latch.
- R7: Configuration bytes sit at 0xE0–0xE7 (pins 10–17), 0xE8–0xED (pins 20–25) and 0xF5–0xFC (pins 30–37). In each byte, bit 0 = input, bit 1 = invert and bit 3 = alternate. A read returns those three bits with all other bits 0. Unmapped addresses read 0x00 and ignore writes.
- R8: A pin whose configuration bit 0 is 0 has its `pin_oe` bit at 1. Its `pin_o` bit is the latch XOR the invert bit. This takes effect on the clock after the configuration write.
- R9: For an input pin, a data read returns the synchronized pin level XOR the invert bit. A change on `pin_i` shows in reads two clock edges later.
- R10: For an output pin, a data read returns the latch value, without inversion.
- R11: An output pin with the alternate bit set drives `pin_o` from its `alt_i` bit and ignores its latch. An input pin with the alternate bit set stays an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration-space write strobe |
| cfg_addr | input | 8 | Configuration-space address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 8 | I/O address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (combinational, 0 when not hit) |
| pin_i | input | 22 | Pad input levels; bits 7:0 are pins 10–17, 13:8 are 20–25, 21:14 are 30–37 |
| alt_i | input | 22 | Alternate-function output levels, same bit order |
| pin_o | output | 22 | Pad output levels |
| pin_oe | output | 22 | Pad output enables, 1 = drive |

## Verification
The hardest state to reach from the ports combines a moved window, a retained index and mixed pin modes. A read can only be predicted if the bench knows which pair is live, which index the register still holds from earlier, and how every pin in the group is configured. The stimulus builds that state in steps. It enables pair 3, then fills groups with inputs, outputs, inverted and alternate pins. It then moves the window through the other three pairs without rewriting the index, and disables and re-enables it. After each move it reads the old and new pair addresses and checks `pin_o` under the output-enable mask.

// File: rtl/gpio_window_bank.sv
module gpio_window_bank #(
  parameter logic [7:0] CTRL_ADDR = 8'h10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_addr,
  input  logic [7:0]  cfg_wdata,
  output logic [7:0]  cfg_rdata,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [7:0]  io_addr,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  input  logic [21:0] pin_i,
  input  logic [21:0] alt_i,
  output logic [21:0] pin_o,
  output logic [21:0] pin_oe
);
  localparam int NA = 8;
  localparam int NB = 6;
  localparam int NC = 8;
  localparam int NP = NA + NB + NC;
  localparam int BB = NA;
  localparam int BC = NA + NB;

  logic          ctrl_en;
  logic [1:0]    ctrl_sel;
  logic [7:0]    idx;
  logic [NP-1:0] latch, dir_in, inv, alt, sync1, sync2, view;
  logic [7:0]    idx_port, dat_port;
  logic          hit_idx, hit_dat;
  logic [5:0]    slot;

  function automatic logic [5:0] cfg_slot(input logic [7:0] a);
    if (a >= 8'hE0 && a <= 8'hED) return {1'b1, 5'(a - 8'hE0)};
    if (a >= 8'hF5 && a <= 8'hFC) return {1'b1, 5'(a - 8'hF5 + 8'(BC))};
    return 6'd0;
  endfunction

  always_comb begin
    case (ctrl_sel)
      2'd0:    idx_port = 8'hE0;
      2'd1:    idx_port = 8'hE2;
      2'd2:    idx_port = 8'hE4;
      default: idx_port = 8'hEA;
    endcase
  end

  assign dat_port = idx_port + 8'd1;
  assign hit_idx  = ctrl_en && io_addr == idx_port;
  assign hit_dat  = ctrl_en && io_addr == dat_port;
  assign slot     = cfg_slot(cfg_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en  <= 1'b0;
      ctrl_sel <= 2'd0;
      idx      <= 8'd0;
      latch    <= '0;
      dir_in   <= '1;
      inv      <= '0;
      alt      <= '0;
      sync1    <= '0;
      sync2    <= '0;
    end else begin
      sync1 <= pin_i;
      sync2 <= sync1;
      if (cfg_wr) begin
        if (cfg_addr == CTRL_ADDR) begin
          ctrl_en  <= cfg_wdata[7];
          ctrl_sel <= cfg_wdata[1:0];
        end else if (slot[5]) begin
          dir_in[slot[4:0]] <= cfg_wdata[0];
          inv[slot[4:0]]    <= cfg_wdata[1];
          alt[slot[4:0]]    <= cfg_wdata[3];
        end
      end
      if (io_wr && hit_idx) idx <= io_wdata;
      if (io_wr && hit_dat) begin
        case (idx)
          8'd1:    latch[BB-1:0]  <= io_wdata;
          8'd2:    latch[BC-1:BB] <= io_wdata[NB-1:0];
          8'd3:    latch[NP-1:BC] <= io_wdata;
          default: ;
        endcase
      end
    end
  end

  assign view = (dir_in & (sync2 ^ inv)) | (~dir_in & latch);

  always_comb begin
    io_rdata = 8'd0;
    if (io_rd && hit_idx) io_rdata = idx;
    else if (io_rd && hit_dat) begin
      case (idx)
        8'd1:    io_rdata = view[BB-1:0];
        8'd2:    io_rdata = {2'b00, view[BC-1:BB]};
        8'd3:    io_rdata = view[NP-1:BC];
        default: io_rdata = 8'd0;
      endcase
    end
  end

  always_comb begin
    cfg_rdata = 8'd0;
    if (cfg_addr == CTRL_ADDR) cfg_rdata = {ctrl_en, 5'd0, ctrl_sel};
    else if (slot[5])
      cfg_rdata = {4'd0, alt[slot[4:0]], 1'b0, inv[slot[4:0]], dir_in[slot[4:0]]};
  end

  assign pin_oe = ~dir_in;
  assign pin_o  = (alt & alt_i) | (~alt & (latch ^ inv));
endmodule

// File: rtl/gpio_window_bank_chk.sv
module gpio_window_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        io_wr,
  input logic        io_rd,
  input logic [7:0]  io_addr,
  input logic [7:0]  io_rdata,
  input logic        cfg_wr,
  input logic [7:0]  cfg_addr,
  input logic [7:0]  cfg_wdata,
  input logic        en,
  input logic [1:0]  sel,
  input logic [7:0]  idx,
  input logic [21:0] alt,
  input logic [21:0] alt_i,
  input logic [21:0] pin_o,
  input logic [21:0] pin_oe
);
  logic [7:0] dport;
  always_comb begin
    case (sel)
      2'd0:    dport = 8'hE1;
      2'd1:    dport = 8'hE3;
      2'd2:    dport = 8'hE5;
      default: dport = 8'hEB;
    endcase
  end

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && io_rd) |-> io_rdata == 8'd0); // R2
  AST_INDEX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr |=> $stable(idx)); // R4
  AST_GROUPB_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en && io_rd && io_addr == dport && idx == 8'd2) |-> io_rdata[7:6] == 2'b00); // R5
  AST_UNUSED_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en && io_rd && io_addr == dport && (idx == 8'd0 || idx > 8'd3)) |-> io_rdata == 8'd0); // R6
  AST_DIR_AFTER_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == 8'hE0) |=> pin_oe[0] == !$past(cfg_wdata[0])); // R8
  AST_ALT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_o ^ alt_i) & alt & pin_oe) == 22'd0); // R11
endmodule

bind gpio_window_bank gpio_window_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
  .io_rdata(io_rdata), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
  .en(ctrl_en), .sel(ctrl_sel), .idx(idx), .alt(alt), .alt_i(alt_i),
  .pin_o(pin_o), .pin_oe(pin_oe)
);

// File: tb/gpio_window_bank_test.sv
module gpio_window_bank_test;
  localparam logic [7:0] CTRL = 8'h10;
  localparam int K_IO = 0, K_CFG = 1, K_OE = 2, K_OUT = 3;

  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0, io_wr = 0, io_rd = 0;
  logic [7:0] cfg_addr = 0, cfg_wdata = 0, io_addr = 0, io_wdata = 0;
  logic [7:0] cfg_rdata, io_rdata;
  logic [21:0] pin_i = 0, alt_i = 0, pin_o, pin_oe;
  logic smp = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { int kind; logic [21:0] exp; string tag; } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  gpio_window_bank #(.CTRL_ADDR(CTRL)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_wr(io_wr), .io_rd(io_rd),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .pin_i(pin_i), .alt_i(alt_i), .pin_o(pin_o), .pin_oe(pin_oe));

  always @(negedge clk) begin
    if (smp && q.size() > 0) begin
      item_t it;
      logic [21:0] act;
      it = q.pop_front();
      case (it.kind)
        K_IO:    act = {14'd0, io_rdata};
        K_CFG:   act = {14'd0, cfg_rdata};
        K_OE:    act = pin_oe;
        default: act = pin_o & pin_oe;
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1; cyc(); cfg_wr = 0;
  endtask

  task automatic io_write(input logic [7:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1; cyc(); io_wr = 0;
  endtask

  task automatic probe(input int kind, input logic [7:0] a, input logic [21:0] e, input string tag);
    item_t it;
    it.kind = kind; it.exp = e; it.tag = tag;
    q.push_back(it);
    if (kind == K_IO) begin io_addr = a; io_rd = 1; end
    if (kind == K_CFG) cfg_addr = a;
    smp = 1; cyc(); smp = 0; io_rd = 0;
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1; cyc();
    // R1 reset state
    probe(K_OE, 0, 22'd0, "R1 oe");
    probe(K_CFG, 8'hE0, 22'h01, "R1 cfg E0");
    probe(K_CFG, 8'hFC, 22'h01, "R1 cfg FC");
    probe(K_CFG, CTRL, 22'h00, "R1 ctrl");
    // R2 disabled window ignores writes
    io_write(8'hE0, 8'h01);
    io_write(8'hE1, 8'hFF);
    probe(K_IO, 8'hE1, 22'h00, "R2 disabled read");
    // R3 pair 3, R4 index
    cfg_write(CTRL, 8'h83);
    probe(K_IO, 8'hEA, 22'h00, "R2 R4 index untouched while disabled");
    io_write(8'hEA, 8'h01);
    probe(K_IO, 8'hEA, 22'h01, "R4 index readback");
    probe(K_IO, 8'hEB, 22'h00, "R2 latch untouched while disabled");
    io_write(8'hEB, 8'hA5);
    for (int i = 0; i < 8; i++) cfg_write(8'hE0 + 8'(i), 8'h00);
    probe(K_OE, 0, 22'h0000FF, "R8 oe group A");
    probe(K_OUT, 0, 22'h0000A5, "R8 pin_o");
    probe(K_IO, 8'hEB, 22'hA5, "R10 output readback");
    cfg_write(8'hE1, 8'h02);
    probe(K_OUT, 0, 22'h0000A7, "R8 invert output");
    probe(K_IO, 8'hEB, 22'hA5, "R10 readback not inverted");
    // R5 group B, R9 input sync
    io_write(8'hEA, 8'h02);
    io_write(8'hEB, 8'hFF);
    cfg_write(8'hE8, 8'h00);
    probe(K_IO, 8'hEB, 22'h01, "R5 group B top bits");
    pin_i = 22'h002A00;
    probe(K_IO, 8'hEB, 22'h01, "R9 sync stage 0");
    probe(K_IO, 8'hEB, 22'h01, "R9 sync stage 1");
    probe(K_IO, 8'hEB, 22'h2B, "R9 synced input");
    cfg_write(8'hE9, 8'h03);
    probe(K_IO, 8'hEB, 22'h29, "R9 inverted input");
    // R6 unused index
    io_write(8'hEA, 8'h05);
    probe(K_IO, 8'hEB, 22'h00, "R6 unused read");
    io_write(8'hEB, 8'h55);
    io_write(8'hEA, 8'h01);
    probe(K_IO, 8'hEB, 22'hA5, "R6 write discarded");
    // R3 other pairs, index retained
    cfg_write(CTRL, 8'h81);
    probe(K_IO, 8'hEB, 22'h00, "R3 old pair dead");
    probe(K_IO, 8'hE3, 22'hA5, "R3 R4 pair 1");
    cfg_write(CTRL, 8'h82);
    probe(K_IO, 8'hE5, 22'hA5, "R3 pair 2");
    cfg_write(CTRL, 8'h80);
    probe(K_IO, 8'hE1, 22'hA5, "R3 pair 0");
    probe(K_IO, 8'hE3, 22'h00, "R3 pair 1 inactive");
    // R7 config readback
    cfg_write(8'hF5, 8'hFF);
    probe(K_CFG, 8'hF5, 22'h0B, "R7 field readback");
    cfg_write(8'hEE, 8'hFF);
    probe(K_CFG, 8'hEE, 22'h00, "R7 unmapped EE");
    probe(K_CFG, 8'hF4, 22'h00, "R7 unmapped F4");
    probe(K_CFG, CTRL, 22'h80, "R7 ctrl readback");
    // R11 alternate
    cfg_write(8'hFC, 8'h08);
    alt_i = 22'h200000;
    probe(K_OE, 0, 22'h2001FF, "R11 oe");
    probe(K_OUT, 0, 22'h2001A7, "R11 alt high");
    alt_i = 22'h0;
    probe(K_OUT, 0, 22'h0001A7, "R11 alt low");
    io_write(8'hE0, 8'h03);
    io_write(8'hE1, 8'hFF);
    probe(K_OUT, 0, 22'h0001A7, "R11 latch ignored");
    probe(K_IO, 8'hE1, 22'h81, "R11 R9 group C view");
    // R2 disable again
    cfg_write(CTRL, 8'h00);
    io_write(8'hE0, 8'h01);
    io_write(8'hE1, 8'h00);
    probe(K_IO, 8'hE1, 22'h00, "R2 disabled read");
    cfg_write(CTRL, 8'h80);
    probe(K_IO, 8'hE1, 22'h81, "R2 nothing changed");
    cyc();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule